// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches a processor for lost control using one free-running counter that advances once per instruction slot. The instruction clock runs at a third of the system clock, so slots arrive as a one-cycle enable on the system clock. The first wrap of the counter only raises a warning flag. A second wrap while the warning is still standing and the watchdog is armed produces a one-cycle reset request. Software keeps the watchdog quiet by issuing the restart command. That command clears the counter and the warning, and it tells the core to skip the next instruction when the warning was set. Code can therefore tell whether it was late.

The watchdog comes out of system reset armed, and entry to RAM backup mode arms it again. It can be disarmed only by a disable command whose very next instruction slot carries the restart command. A disable followed by anything else is forgotten. The reset generator and the instruction pipeline are outside the block. The block drives them through the reset request and the skip indication.

Top module: `twostage_wdog`

## Requirements
- R1: While `rst_n` is low, `wd_reset` and `skip_next` are 0. After reset the counter and the warning are clear and the watchdog is armed.
- R2: The counter advances by one on each cycle with `slot_en`=1. The slot that wraps it from all ones to zero (the 2^CNT_W-th slot after a clear) sets the warning. That first wrap gives no `wd_reset`.
- R3: A wrap while the warning is set and the watchdog is armed makes `wd_reset` 1 for exactly one cycle, in the cycle after the wrapping slot.
- R4: A slot carrying `cmd_restart` while the warning is set clears the warning and makes `skip_next` 1 for exactly one cycle, in the cycle after that slot.
- R5: A slot carrying `cmd_restart` while the warning is clear leaves `skip_next` at 0.
- R6: A slot carrying `cmd_restart` clears the counter, and it does not count as an increment. A further 2^CNT_W slots are then needed to reach the next wrap.
- R7: A slot carrying `cmd_disable`, followed by a restart in the very next slot, disarms the watchdog. After that no `wd_reset` is produced, however many wraps occur.
- R8: If the slot after a disable carries no restart, the pending disable is dropped, and a later restart does not disarm the watchdog.
- R9: A disable with no restart in the next slot leaves the watchdog armed.
- R10: `backup_enter` (taken in any cycle) arms the watchdog and drops a pending disable.
- R11: In cycles with `slot_en`=0, `cmd_restart` and `cmd_disable` are ignored, and the counter, warning, arm state and outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| slot_en | input | 1 | One-cycle instruction-slot enable (system clock / 3) |
| backup_enter | input | 1 | Strobe on entry to RAM backup mode |
| cmd_restart | input | 1 | Watchdog restart command, qualified by `slot_en` |
| cmd_disable | input | 1 | Watchdog disable command, qualified by `slot_en` |
| wd_reset | output | 1 | Registered one-cycle reset request |
| skip_next | output | 1 | Registered one-cycle skip-next-instruction indication |

## Verification
Both outputs are registered, so `wd_reset` and `skip_next` change on the clock edge that samples the causing slot. They are due one cycle after that slot's stimulus, and never later. The driver applies each stimulus on a falling edge and works out the expected pair from its own model of the counter, warning and arm state. It queues that pair at the next rising edge. The monitor takes the pair off the queue on the falling edge that follows and compares it, so every result is sampled exactly one cycle after its cause, half a period clear of the edge. The counter width is reduced in the bench so that a wrap arrives in 16 slots.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // next counter value for one instruction slot
  function automatic logic [31:0] wd_next_count(input logic [31:0] cur, input logic clr,
                                                input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    if (clr) return 32'd0;
    return (cur + 32'd1) & mask;
  endfunction

  // counter sits at its top value, so the next slot wraps it
  function automatic logic wd_at_top(input logic [31:0] cur, input int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    return (cur & mask) == mask;
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_en,
  input  logic             clr_req,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  import wdog_pkg::*;

  logic [31:0] cur_w;
  logic [31:0] nxt_w;

  assign cur_w    = 32'(count);
  assign nxt_w    = wd_next_count(cur_w, clr_req, CNT_W);
  assign wrap_evt = slot_en && !clr_req && wd_at_top(cur_w, CNT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (slot_en) count <= nxt_w[CNT_W-1:0];
  end
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  input  logic backup_enter,
  input  logic cmd_restart,
  input  logic cmd_disable,
  output logic armed,
  output logic dis_pending,
  output logic disarm_evt
);
  assign disarm_evt = slot_en && cmd_restart && dis_pending && !backup_enter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b1;
      dis_pending <= 1'b0;
    end else begin
      if (backup_enter) armed <= 1'b1;
      else if (disarm_evt) armed <= 1'b0;

      if (backup_enter) dis_pending <= 1'b0;
      else if (slot_en) dis_pending <= cmd_disable;
    end
  end
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  input  logic cmd_restart,
  input  logic wrap_evt,
  input  logic armed,
  output logic warn,
  output logic expire_evt,
  output logic late_restart,
  output logic wd_reset_q,
  output logic skip_q
);
  assign expire_evt   = wrap_evt && warn && armed;
  assign late_restart = slot_en && cmd_restart && warn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warn       <= 1'b0;
      wd_reset_q <= 1'b0;
      skip_q     <= 1'b0;
    end else begin
      if (slot_en && cmd_restart) warn <= 1'b0;
      else if (wrap_evt) warn <= 1'b1;
      wd_reset_q <= expire_evt;
      skip_q     <= late_restart;
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  input  logic backup_enter,
  input  logic cmd_restart,
  input  logic cmd_disable,
  output logic wd_reset,
  output logic skip_next
);
  logic [CNT_W-1:0] count;
  logic             wrap_evt;
  logic             clr_req;
  logic             armed;
  logic             dis_pending;
  logic             disarm_evt;
  logic             warn;
  logic             expire_evt;
  logic             late_restart;

  assign clr_req = slot_en && cmd_restart;

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_en  (slot_en),
    .clr_req  (clr_req),
    .count    (count),
    .wrap_evt (wrap_evt)
  );

  wdog_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_en      (slot_en),
    .backup_enter (backup_enter),
    .cmd_restart  (cmd_restart),
    .cmd_disable  (cmd_disable),
    .armed        (armed),
    .dis_pending  (dis_pending),
    .disarm_evt   (disarm_evt)
  );

  wdog_flags u_flg (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_en      (slot_en),
    .cmd_restart  (cmd_restart),
    .wrap_evt     (wrap_evt),
    .armed        (armed),
    .warn         (warn),
    .expire_evt   (expire_evt),
    .late_restart (late_restart),
    .wd_reset_q   (wd_reset),
    .skip_q       (skip_next)
  );
endmodule

// File: rtl/twostage_wdog_chk.sv
module twostage_wdog_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_en,
  input logic             backup_enter,
  input logic             cmd_restart,
  input logic             cmd_disable,
  input logic             wd_reset,
  input logic             skip_next,
  input logic [CNT_W-1:0] count,
  input logic             wrap_evt,
  input logic             warn,
  input logic             armed
);
  AST_WARN_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt) |=> warn); // R2
  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> $past(wrap_evt && warn && armed)); // R3
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset); // R3
  AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_next |-> $past(slot_en && cmd_restart && warn)); // R4
  AST_NO_EARLY_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && cmd_restart && !warn) |=> !skip_next); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && cmd_restart) |=> (count == '0 && !warn)); // R6
  AST_DISARMED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wd_reset); // R7
  AST_BACKUP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    backup_enter |=> armed); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en && !backup_enter) |=> ($stable(count) && $stable(warn) && $stable(armed)
                                     && !wd_reset && !skip_next)); // R11
endmodule

bind twostage_wdog twostage_wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_en      (slot_en),
  .backup_enter (backup_enter),
  .cmd_restart  (cmd_restart),
  .cmd_disable  (cmd_disable),
  .wd_reset     (wd_reset),
  .skip_next    (skip_next),
  .count        (count),
  .wrap_evt     (wrap_evt),
  .warn         (warn),
  .armed        (armed)
);

// File: tb/sim_twostage_wdog.sv
`timescale 1ns/1ps
module sim_twostage_wdog;
  localparam int unsigned W    = 4;
  localparam int          SPAN = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0;
  logic backup_enter = 1'b0;
  logic cmd_restart = 1'b0;
  logic cmd_disable = 1'b0;
  logic wd_reset;
  logic skip_next;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state of the bench's own model
  int m_cnt = 0;
  bit m_warn = 1'b0;
  bit m_arm = 1'b1;
  bit m_pend = 1'b0;

  bit [1:0] exp_q[$];
  string    tag_q[$];

  always #2.5 clk = ~clk;

  twostage_wdog #(.CNT_W(W)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_en      (slot_en),
    .backup_enter (backup_enter),
    .cmd_restart  (cmd_restart),
    .cmd_disable  (cmd_disable),
    .wd_reset     (wd_reset),
    .skip_next    (skip_next)
  );

  task automatic check(input string tag, input bit [1:0] act, input bit [1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wd_reset/skip_next actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle of stimulus; expected outputs are queued for the monitor
  task automatic step(input bit t, input bit r, input bit d, input bit b, input string tag);
    bit ew, es;
    bit old_warn, old_arm, old_pend;
    old_warn = m_warn; old_arm = m_arm; old_pend = m_pend;
    ew = 1'b0; es = 1'b0;
    slot_en = t; cmd_restart = r; cmd_disable = d; backup_enter = b;
    if (t) begin
      if (r) begin
        es = old_warn;
        m_warn = 1'b0;
        m_cnt = 0;
        if (old_pend && !b) m_arm = 1'b0;
      end else if (m_cnt == SPAN - 1) begin
        m_cnt = 0;
        ew = old_warn && old_arm;
        m_warn = 1'b1;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_pend = d;
    end
    if (b) begin
      m_arm = 1'b1;
      m_pend = 1'b0;
    end
    @(posedge clk);
    exp_q.push_back({ew, es});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare one cycle after each stimulus, half a period off the edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit [1:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(tg, {wd_reset, skip_next}, e);
    end
  end

  // watchdog for the bench itself
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {wd_reset, skip_next}, 2'b00);
    cmd_restart = 1'b1; slot_en = 1'b1;
    @(negedge clk);
    check("R1 reset held", {wd_reset, skip_next}, 2'b00);
    cmd_restart = 1'b0; slot_en = 1'b0;
    rst_n = 1'b1;

    run(SPAN, "R2 first wrap only warns");
    run(SPAN, "R3 second wrap resets");
    run(SPAN, "R3 stays armed, wraps again");

    // commands without slot enable are ignored
    step(1'b0, 1'b1, 1'b0, 1'b0, "R11 restart off-slot");
    step(1'b0, 1'b0, 1'b1, 1'b0, "R11 disable off-slot");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R11 restart off-slot again");

    step(1'b1, 1'b1, 1'b0, 1'b0, "R4 late restart skips");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R5 restart without warning");

    run(10, "R6 count");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R6 restart mid-count");
    run(SPAN - 1, "R6 no wrap yet");
    run(SPAN + 2, "R6 wrap after full span");

    step(1'b1, 1'b0, 1'b1, 1'b0, "R7 disable");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 restart next slot");
    run(3 * SPAN, "R7 disarmed, no reset");

    step(1'b0, 1'b0, 1'b0, 1'b1, "R10 backup entry");
    run(2 * SPAN + 2, "R10 rearmed");

    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 clean start");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R8 disable");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R8 gap slot");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 late restart");
    run(2 * SPAN + 2, "R8 still armed");

    step(1'b1, 1'b0, 1'b1, 1'b0, "R9 lone disable");
    run(2 * SPAN + 2, "R9 still armed");

    // instruction slots every third cycle, commands on off cycles too
    for (int i = 0; i < 6 * SPAN; i++) begin
      bit t;
      t = (i % 3 == 0);
      step(t, !t && (i % 5 == 1), !t && (i % 7 == 2), 1'b0, "R11 divided slots");
    end
    step(1'b1, 1'b0, 1'b1, 1'b0, "R11 disable");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R11 off-slot restart");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R11 idle");
    step(1'b1, 1'b1, 1'b0, 1'b0, "R7 restart on next slot");
    run(3 * SPAN, "R7 disarmed via divided slots");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule